// File: doc/BRIEF.md
# Multi-Interface Transmit Command Sequencer

This block sequences transmit work for a network device whose control registers are shared by several virtual interfaces. Each interface posts a transmit descriptor: a buffer address, a segment length, a "more segments follow" flag and a "checksum insertion wanted" flag. The sequencer keeps a queue of interface indices in posting order. It serves the interface at the head of the queue by copying each segment over a DMA request/done handshake into a packet assembly buffer. When a segment finishes, it writes a completion word back for that interface. On the last segment of a packet it hands the assembled packet to the transmit FIFO.

A packet may span several segments. While a packet is only partly assembled, the sequencer stays with that interface. Other interfaces that have already posted wait in the queue until the owning interface posts its final segment. Before a copy starts, the sequencer checks that the FIFO has room for the bytes already assembled plus the new segment. It also waits for the DMA engine to be idle. Two interrupt pulses report DMA completion and a nearly full FIFO. A sticky flag records a segment that would overflow the 16384-byte assembly buffer.

Top module: `tx_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, `dma_req`, `done_we`, `push_valid`, `intr_txdma`, `intr_txfull` and `err_ovf` are 0, every bit of `if_busy` is 0 and the queue is empty.
- R2: A post (`post_valid` high for one cycle) is accepted only if `if_busy[post_idx]` is 0. An accepted post stores the descriptor and sets the busy bit. A post to a busy interface is ignored and leaves the stored descriptor unchanged.
- R3: An accepted post appends its index to the service queue unless the queue is non-empty and that index is already at its head. Interfaces are served in the order they were appended.
- R4: The sequencer leaves idle only when `enable` is 1, the queue is non-empty and the head interface has a pending descriptor. It always serves the head interface.
- R5: A segment copy is started only when `fifo_free >= assembled_bytes + segment_length`. Equality is enough.
- R6: `dma_req` pulses for one cycle, and never while `dma_busy` is 1. `dma_addr` and `dma_len` come from the head descriptor, and `dma_off` equals the bytes already assembled for the current packet.
- R7: Each finished segment raises `done_we` for one cycle, with `done_idx` set to the head interface, and then clears that interface's busy bit. `done_word[15:0]` holds the copied length, bit 16 is Complete (always 1) and bit 17 is Dropped.
- R8: For a segment with the More flag set, the assembled byte count advances by the segment length and `intr_txdma` pulses. The interface stays at the head, and no other interface is served until that interface's final segment completes.
- R9: For a final segment, `push_valid` pulses with `push_len` equal to the total packet bytes and `push_csum` equal to the descriptor's checksum flag. The head is then removed and `intr_txdma` pulses. The sequencer goes straight to the wait-for-space state if indices remain, and otherwise to idle.
- R10: `intr_txfull` pulses together with `push_valid` exactly when `fifo_free < push_len + max_copy`.
- R11: A segment that would bring the assembled bytes above 16384 sets the sticky flag `err_ovf`. It is completed with `done_word` showing length 0, Complete set and Dropped set. The partial packet is discarded, the head is removed, `intr_txdma` pulses and nothing is pushed.
- R12: The queue holds at most NUM_IF entries and never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Transmit sequencing enabled |
| post_valid | input | 1 | Descriptor post strobe |
| post_idx | input | 2 | Posting interface index |
| post_addr | input | 32 | Segment buffer address |
| post_len | input | 16 | Segment length in bytes |
| post_more | input | 1 | More segments follow |
| post_csum | input | 1 | Request checksum insertion |
| if_busy | output | 4 | Pending-descriptor bit per interface |
| fifo_free | input | 16 | Free bytes in transmit FIFO |
| max_copy | input | 16 | Free-space threshold for the full interrupt |
| dma_busy | input | 1 | DMA engine busy |
| dma_req | output | 1 | Start a segment copy |
| dma_addr | output | 32 | Source address of the copy |
| dma_len | output | 16 | Copy length |
| dma_off | output | 15 | Destination offset in the assembly buffer |
| dma_done | input | 1 | Copy finished |
| done_we | output | 1 | Completion word write strobe |
| done_idx | output | 2 | Interface receiving the completion word |
| done_word | output | 18 | Completion word |
| push_valid | output | 1 | Packet push into the transmit FIFO |
| push_len | output | 15 | Pushed packet length |
| push_csum | output | 1 | Pushed packet wants checksum insertion |
| intr_txdma | output | 1 | Segment completion interrupt pulse |
| intr_txfull | output | 1 | FIFO nearly full interrupt pulse |
| err_ovf | output | 1 | Sticky assembly overflow flag |

## Verification
The bench checks that an interface left partly assembled blocks the interfaces queued behind it. A design that served queue order without this pinning would start a DMA for the second interface while the first packet is still open, and the DMA order would come out wrong. It tests the FIFO space rule at and just below equality, a DMA engine held busy, and the full-interrupt threshold on both sides of the boundary. These catch an off-by-one compare or a copy started too early. A 16384-byte packet must be pushed whole, and a segment one step past that must be dropped and reported. After the drop, a fresh packet must start at offset 0, which exposes a design that forgets to clear the partial packet.

// File: rtl/tx_seq_pkg.sv
// Package: shared state encoding for the transmit command sequencer.
// Assumes nothing beyond SystemVerilog enums.
package tx_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // nothing to serve
        ST_WAIT  = 3'd1,   // waiting for FIFO room
        ST_START = 3'd2,   // waiting for DMA engine to be idle
        ST_COPY  = 3'd3,   // DMA in flight
        ST_FIN   = 3'd4,   // segment finished, report and maybe push
        ST_DROP  = 3'd5    // segment refused, report and discard
    } seq_state_t;
endpackage

// File: rtl/tx_seq_queue.sv
// Module: circular queue of interface indices in arrival order.
// Assumes DEPTH >= 2; callers never push when full (guaranteed by sizing).
module tx_seq_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign head    = mem[rd_ptr];
    assign do_pop  = pop && !empty;
    assign do_push = push && (count != CNT_W'(DEPTH) || do_pop);

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/tx_seq_desc.sv
// Module: per-interface descriptor store with pending (busy) bits.
// Assumes a set and a clear never target the same interface in one cycle;
// set wins if they do.
module tx_seq_desc #(
    parameter int NUM_IF = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_we,
    input  logic [$clog2(NUM_IF)-1:0] set_idx,
    input  logic [ADDR_W-1:0]         set_addr,
    input  logic [LEN_W-1:0]          set_len,
    input  logic                      set_more,
    input  logic                      set_csum,
    input  logic                      clr_we,
    input  logic [$clog2(NUM_IF)-1:0] clr_idx,
    input  logic [$clog2(NUM_IF)-1:0] rd_idx,
    output logic [NUM_IF-1:0]         busy,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic [LEN_W-1:0]          rd_len,
    output logic                      rd_more,
    output logic                      rd_csum
);
    logic [ADDR_W-1:0] d_addr [NUM_IF];
    logic [LEN_W-1:0]  d_len  [NUM_IF];
    logic [NUM_IF-1:0] d_more, d_csum;

    for (genvar g = 0; g < NUM_IF; g++) begin : g_if
        // Descriptor fields are captured on an accepted post.
        always_ff @(posedge clk) begin
            if (set_we && set_idx == g) begin
                d_addr[g] <= set_addr;
                d_len[g]  <= set_len;
                d_more[g] <= set_more;
                d_csum[g] <= set_csum;
            end
        end

        // Pending bit: set on post, cleared on completion write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                busy[g] <= 1'b0;
            else if (set_we && set_idx == g)
                busy[g] <= 1'b1;
            else if (clr_we && clr_idx == g)
                busy[g] <= 1'b0;
        end
    end

    assign rd_addr = d_addr[rd_idx];
    assign rd_len  = d_len[rd_idx];
    assign rd_more = d_more[rd_idx];
    assign rd_csum = d_csum[rd_idx];
endmodule

// File: rtl/tx_seq_fsm.sv
// Module: segment sequencing state machine with assembly byte tracking.
// Assumes LEN_W >= ASM_W and that the head descriptor is stable while served.
module tx_seq_fsm
    import tx_seq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int SPACE_W   = 16,
    parameter int CNT_W     = 3,
    parameter int BUF_BYTES = 16384,
    parameter int ASM_W     = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               q_empty,
    input  logic [CNT_W-1:0]   q_count,
    input  logic               head_pending,
    input  logic [LEN_W-1:0]   hd_len,
    input  logic               hd_more,
    input  logic [SPACE_W-1:0] fifo_free,
    input  logic [SPACE_W-1:0] max_copy,
    input  logic               dma_busy,
    input  logic               dma_done,
    output seq_state_t         state,
    output logic               dma_req,
    output logic [ASM_W-1:0]   asm_len,
    output logic               seg_done,
    output logic               seg_drop,
    output logic               pop,
    output logic               push_valid,
    output logic [ASM_W-1:0]   push_len,
    output logic               txfull,
    output logic               err_ovf
);
    localparam int CMP_W = ((LEN_W > SPACE_W) ? LEN_W : SPACE_W) + 2;

    seq_state_t       state_nx;
    logic [CMP_W-1:0] need;
    logic             ovf, room, more_left;

    // Bytes the packet would hold after this segment, overflow and room tests.
    always_comb begin
        need      = CMP_W'(asm_len) + CMP_W'(hd_len);
        ovf       = need > CMP_W'(BUF_BYTES);
        room      = CMP_W'(fifo_free) >= need;
        more_left = q_count > CNT_W'(1);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (enable && !q_empty && head_pending) state_nx = ST_WAIT;
            ST_WAIT:  if (ovf) state_nx = ST_DROP;
                      else if (room) state_nx = ST_START;
            ST_START: if (!dma_busy) state_nx = ST_COPY;
            ST_COPY:  if (dma_done) state_nx = ST_FIN;
            ST_FIN:   if (hd_more) state_nx = ST_IDLE;
                      else state_nx = more_left ? ST_WAIT : ST_IDLE;
            ST_DROP:  state_nx = more_left ? ST_WAIT : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Assembled byte count: grows on non-final segments, clears on push or drop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            asm_len <= '0;
        else if (state == ST_FIN && hd_more)
            asm_len <= asm_len + ASM_W'(hd_len);
        else if (state == ST_FIN || state == ST_DROP)
            asm_len <= '0;
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                err_ovf <= 1'b0;
        else if (state == ST_DROP) err_ovf <= 1'b1;
    end

    // Decoded strobes of the finishing states.
    always_comb begin
        dma_req    = (state == ST_START) && !dma_busy;
        seg_done   = (state == ST_FIN);
        seg_drop   = (state == ST_DROP);
        push_valid = seg_done && !hd_more;
        pop        = push_valid || seg_drop;
        push_len   = asm_len + ASM_W'(hd_len);
        txfull     = push_valid &&
                     (CMP_W'(fifo_free) < CMP_W'(push_len) + CMP_W'(max_copy));
    end
endmodule

// File: rtl/tx_cmd_seq.sv
// Module: top of the multi-interface transmit command sequencer.
// Accepts descriptor posts, queues interface indices, drives the FSM and
// formats completion words. Assumes NUM_IF is a power of two >= 2.
module tx_cmd_seq
    import tx_seq_pkg::*;
#(
    parameter int NUM_IF    = 4,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int SPACE_W   = 16,
    parameter int BUF_BYTES = 16384,
    localparam int IDX_W    = $clog2(NUM_IF),
    localparam int ASM_W    = $clog2(BUF_BYTES + 1),
    localparam int CNT_W    = $clog2(NUM_IF + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               post_valid,
    input  logic [IDX_W-1:0]   post_idx,
    input  logic [ADDR_W-1:0]  post_addr,
    input  logic [LEN_W-1:0]   post_len,
    input  logic               post_more,
    input  logic               post_csum,
    output logic [NUM_IF-1:0]  if_busy,
    input  logic [SPACE_W-1:0] fifo_free,
    input  logic [SPACE_W-1:0] max_copy,
    input  logic               dma_busy,
    output logic               dma_req,
    output logic [ADDR_W-1:0]  dma_addr,
    output logic [LEN_W-1:0]   dma_len,
    output logic [ASM_W-1:0]   dma_off,
    input  logic               dma_done,
    output logic               done_we,
    output logic [IDX_W-1:0]   done_idx,
    output logic [LEN_W+1:0]   done_word,
    output logic               push_valid,
    output logic [ASM_W-1:0]   push_len,
    output logic               push_csum,
    output logic               intr_txdma,
    output logic               intr_txfull,
    output logic               err_ovf
);
    logic [IDX_W-1:0]  q_head;
    logic [CNT_W-1:0]  q_count;
    logic              q_empty, q_pop, q_push;
    logic              accept;
    logic [ADDR_W-1:0] hd_addr;
    logic [LEN_W-1:0]  hd_len;
    logic              hd_more, hd_csum;
    logic              seg_done, seg_drop;
    logic [ASM_W-1:0]  asm_len;
    seq_state_t        state;

    // Post acceptance and queue append rule.
    always_comb begin
        accept = post_valid && !if_busy[post_idx];
        q_push = accept && !(!q_empty && q_head == post_idx);
    end

    tx_seq_queue #(.DEPTH(NUM_IF), .W(IDX_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (post_idx),
        .pop       (q_pop),
        .head      (q_head),
        .count     (q_count),
        .empty     (q_empty)
    );

    tx_seq_desc #(.NUM_IF(NUM_IF), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (accept),
        .set_idx  (post_idx),
        .set_addr (post_addr),
        .set_len  (post_len),
        .set_more (post_more),
        .set_csum (post_csum),
        .clr_we   (done_we),
        .clr_idx  (q_head),
        .rd_idx   (q_head),
        .busy     (if_busy),
        .rd_addr  (hd_addr),
        .rd_len   (hd_len),
        .rd_more  (hd_more),
        .rd_csum  (hd_csum)
    );

    tx_seq_fsm #(
        .LEN_W(LEN_W), .SPACE_W(SPACE_W), .CNT_W(CNT_W),
        .BUF_BYTES(BUF_BYTES), .ASM_W(ASM_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .q_empty      (q_empty),
        .q_count      (q_count),
        .head_pending (if_busy[q_head]),
        .hd_len       (hd_len),
        .hd_more      (hd_more),
        .fifo_free    (fifo_free),
        .max_copy     (max_copy),
        .dma_busy     (dma_busy),
        .dma_done     (dma_done),
        .state        (state),
        .dma_req      (dma_req),
        .asm_len      (asm_len),
        .seg_done     (seg_done),
        .seg_drop     (seg_drop),
        .pop          (q_pop),
        .push_valid   (push_valid),
        .push_len     (push_len),
        .txfull       (intr_txfull),
        .err_ovf      (err_ovf)
    );

    // Output formatting: DMA fields, completion word, push flags, interrupt.
    always_comb begin
        dma_addr   = hd_addr;
        dma_len    = hd_len;
        dma_off    = asm_len;
        done_we    = seg_done || seg_drop;
        done_idx   = q_head;
        done_word  = {seg_drop, 1'b1, (seg_drop ? LEN_W'(0) : hd_len)};
        push_csum  = push_valid && hd_csum;
        intr_txdma = done_we;
    end
endmodule

// File: rtl/tx_cmd_seq_chk.sv
// Module: assertion checker for tx_cmd_seq, attached with bind.
// Assumes the DMA environment answers each request with one done pulse.
module tx_cmd_seq_chk #(
    parameter int NUM_IF    = 4,
    parameter int BUF_BYTES = 16384,
    parameter int ASM_W     = 15,
    parameter int CNT_W     = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dma_req,
    input logic                      dma_done,
    input logic                      done_we,
    input logic [$clog2(NUM_IF)-1:0] done_idx,
    input logic [NUM_IF-1:0]         if_busy,
    input logic                      push_valid,
    input logic [ASM_W-1:0]          push_len,
    input logic                      intr_txfull,
    input logic                      err_ovf,
    input logic [CNT_W-1:0]          q_count
);
    logic inflight;

    // Tracks an outstanding DMA between request and done.
    always_ff @(posedge clk) begin
        if (!rst_n)        inflight <= 1'b0;
        else if (dma_req)  inflight <= 1'b1;
        else if (dma_done) inflight <= 1'b0;
    end

    AST_ONE_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !inflight);                                   // R6
    AST_DONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        done_we |-> if_busy[done_idx]);                           // R7
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_we |=> !if_busy[$past(done_idx)]);                   // R7
    AST_PUSH_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> done_we);                                  // R9
    AST_FULL_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        intr_txfull |-> push_valid);                              // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (int'(push_len) <= BUF_BYTES));            // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);                                     // R11
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= NUM_IF);                                 // R12
endmodule

bind tx_cmd_seq tx_cmd_seq_chk #(
    .NUM_IF(NUM_IF), .BUF_BYTES(BUF_BYTES), .ASM_W(ASM_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_req     (dma_req),
    .dma_done    (dma_done),
    .done_we     (done_we),
    .done_idx    (done_idx),
    .if_busy     (if_busy),
    .push_valid  (push_valid),
    .push_len    (push_len),
    .intr_txfull (intr_txfull),
    .err_ovf     (err_ovf),
    .q_count     (q_count)
);

// File: tb/sim_tx_cmd_seq.sv
`timescale 1ns/1ps
module sim_tx_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        post_valid = 1'b0;
    logic [1:0]  post_idx = '0;
    logic [31:0] post_addr = '0;
    logic [15:0] post_len = '0;
    logic        post_more = 1'b0, post_csum = 1'b0;
    logic [3:0]  if_busy;
    logic [15:0] fifo_free = 16'hFFFF;
    logic [15:0] max_copy = '0;
    logic        dma_busy = 1'b0;
    logic        dma_req;
    logic [31:0] dma_addr;
    logic [15:0] dma_len;
    logic [14:0] dma_off;
    logic        dma_done = 1'b0;
    logic        done_we;
    logic [1:0]  done_idx;
    logic [17:0] done_word;
    logic        push_valid;
    logic [14:0] push_len;
    logic        push_csum;
    logic        intr_txdma, intr_txfull, err_ovf;

    always #2.5 clk = ~clk;

    tx_cmd_seq u0 (.*);

    int n_chk = 0, n_bad = 0;
    int n_dma = 0, n_txdma = 0, n_full = 0;
    int dma_cnt = 0;
    int cyc = 0;
    logic [62:0] exp_dma [$];   // {addr, len, off}
    logic [19:0] exp_done [$];  // {idx, word}
    logic [15:0] exp_push [$];  // {csum, len}

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compares every produced event with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dma_req) begin
                n_dma++;
                dma_cnt = 3;
                if (exp_dma.size() == 0) chk("R4 unexpected dma", {dma_addr, dma_len}, 0);
                else chk("R6 dma addr/len/off", {dma_addr, dma_len, dma_off}, exp_dma.pop_front());
            end
            if (done_we) begin
                if (exp_done.size() == 0) chk("R7 unexpected done", done_word, 0);
                else chk("R7 done idx/word", {done_idx, done_word}, exp_done.pop_front());
            end
            if (push_valid) begin
                if (exp_push.size() == 0) chk("R9 unexpected push", push_len, 0);
                else chk("R9 push len/csum", {push_csum, push_len}, exp_push.pop_front());
            end
            if (intr_txdma) n_txdma++;
            if (intr_txfull) n_full++;
        end
    end

    // DMA responder: done pulse three cycles after a request.
    always @(posedge clk) begin
        #1;
        dma_done = (dma_cnt == 1);
        if (dma_cnt > 0) dma_cnt--;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R4 actual=%0d expected=<100000", cyc);
            summary();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic post(input logic [1:0] idx, input logic [31:0] a, input logic [15:0] l,
                        input logic more, input logic cs);
        @(posedge clk); #1;
        post_valid = 1; post_idx = idx; post_addr = a; post_len = l;
        post_more = more; post_csum = cs;
        @(posedge clk); #1;
        post_valid = 0;
    endtask

    task automatic exp_seg(input logic [1:0] idx, input logic [31:0] a, input logic [15:0] l,
                           input logic [14:0] off);
        exp_dma.push_back({a, l, off});
        exp_done.push_back({idx, 2'b01, l});
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((exp_dma.size() || exp_done.size() || exp_push.size()) && t < 3000) begin
            step(1); t++;
        end
        step(4);
        chk(req, t < 3000, 1);
    endtask

    initial begin
        int d0, f0;
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk("R1 outputs idle", {dma_req, done_we, push_valid, intr_txdma, intr_txfull, err_ovf}, 0);
        chk("R1 busy clear", if_busy, 0);
        enable = 1;

        // Single segment packet with checksum.
        d0 = n_txdma;
        exp_seg(0, 32'h1000, 100, 0); exp_push.push_back({1'b1, 15'd100});
        post(0, 32'h1000, 100, 0, 1);
        drain("R9 single packet");
        chk("R9 txdma count", n_txdma - d0, 1);

        // Two-segment packet: offset advances.
        d0 = n_txdma;
        exp_seg(1, 32'h2000, 200, 0);
        post(1, 32'h2000, 200, 1, 0);
        drain("R8 first segment");
        chk("R8 txdma on more", n_txdma - d0, 1);
        exp_seg(1, 32'h2400, 50, 200); exp_push.push_back({1'b0, 15'd250});
        post(1, 32'h2400, 50, 0, 0);
        drain("R8 final segment");

        // Pinning: interface 3 waits behind partial interface 2.
        exp_seg(2, 32'h3000, 64, 0);
        post(2, 32'h3000, 64, 1, 1);
        drain("R8 pin open");
        d0 = n_dma;
        post(3, 32'h4000, 10, 0, 0);
        step(40);
        chk("R8 others wait while pinned", n_dma - d0, 0);
        exp_seg(2, 32'h3100, 16, 64); exp_push.push_back({1'b1, 15'd80});
        exp_seg(3, 32'h4000, 10, 0);  exp_push.push_back({1'b0, 15'd10});
        post(2, 32'h3100, 16, 0, 1);
        drain("R3 pin release order");

        // Ignored post to busy interface.
        enable = 0;
        post(0, 32'h500, 30, 0, 0);
        post(0, 32'h900, 99, 0, 1);
        chk("R2 busy bit", if_busy, 4'b0001);
        exp_seg(0, 32'h500, 30, 0); exp_push.push_back({1'b0, 15'd30});
        enable = 1;
        drain("R2 ignored repost");

        // Arrival order 3,1,0.
        enable = 0;
        post(3, 32'h11, 11, 0, 0);
        post(1, 32'h22, 22, 0, 0);
        post(0, 32'h33, 33, 0, 0);
        step(10);
        chk("R4 disabled stays idle", n_dma - d0 - 3, 0);
        exp_seg(3, 32'h11, 11, 0); exp_push.push_back({1'b0, 15'd11});
        exp_seg(1, 32'h22, 22, 0); exp_push.push_back({1'b0, 15'd22});
        exp_seg(0, 32'h33, 33, 0); exp_push.push_back({1'b0, 15'd33});
        enable = 1;
        drain("R3 arrival order");

        // FIFO space rule with equality boundary.
        fifo_free = 39;
        d0 = n_dma;
        post(1, 32'h7000, 40, 0, 0);
        step(30);
        chk("R5 no start below space", n_dma - d0, 0);
        exp_seg(1, 32'h7000, 40, 0); exp_push.push_back({1'b0, 15'd40});
        fifo_free = 40;
        drain("R5 start at equality");
        fifo_free = 16'hFFFF;

        // DMA engine busy.
        dma_busy = 1;
        d0 = n_dma;
        post(2, 32'h8000, 8, 0, 0);
        step(20);
        chk("R6 no request while busy", n_dma - d0, 0);
        exp_seg(2, 32'h8000, 8, 0); exp_push.push_back({1'b0, 15'd8});
        dma_busy = 0;
        drain("R6 request after busy");

        // Full interrupt both sides of the threshold.
        max_copy = 100; fifo_free = 159; f0 = n_full;
        exp_seg(0, 32'h9000, 60, 0); exp_push.push_back({1'b0, 15'd60});
        post(0, 32'h9000, 60, 0, 0);
        drain("R10 full case");
        chk("R10 full raised", n_full - f0, 1);
        fifo_free = 160; f0 = n_full;
        exp_seg(0, 32'h9100, 60, 0); exp_push.push_back({1'b0, 15'd60});
        post(0, 32'h9100, 60, 0, 0);
        drain("R10 no-full case");
        chk("R10 full not raised", n_full - f0, 0);
        max_copy = 0; fifo_free = 16'hFFFF;

        // Maximum packet 16384 accepted.
        exp_seg(0, 32'hA000, 16000, 0);
        post(0, 32'hA000, 16000, 1, 0);
        drain("R11 big first");
        exp_seg(0, 32'hB000, 384, 16000); exp_push.push_back({1'b0, 15'd16384});
        post(0, 32'hB000, 384, 0, 0);
        drain("R11 exact max");
        chk("R11 no error at max", err_ovf, 0);

        // Overflow: drop and recover.
        exp_seg(1, 32'hC000, 10000, 0);
        post(1, 32'hC000, 10000, 1, 0);
        drain("R11 pre-overflow");
        d0 = n_txdma;
        exp_done.push_back({2'd1, 2'b11, 16'd0});
        post(1, 32'hD000, 7000, 0, 0);
        drain("R11 dropped segment");
        chk("R11 error flag", err_ovf, 1);
        chk("R11 txdma on drop", n_txdma - d0, 1);
        exp_seg(1, 32'hE000, 5, 0); exp_push.push_back({1'b0, 15'd5});
        post(1, 32'hE000, 5, 0, 0);
        drain("R11 fresh packet after drop");

        // All four interfaces queued at once: R12 depth.
        enable = 0;
        for (int i = 0; i < 4; i++) post(2'(i), 32'(i * 16), 16'(i + 1), 0, 0);
        for (int i = 0; i < 4; i++) begin
            exp_seg(2'(i), 32'(i * 16), 16'(i + 1), 0);
            exp_push.push_back({1'b0, 15'(i + 1)});
        end
        enable = 1;
        drain("R12 full queue");
        chk("R12 busy cleared", if_busy, 0);
        summary();
    end
endmodule